// File: doc/BRIEF.md
# Write-Once Watchdog Timer with Keyed Service

This block is a system watchdog that sits on a simple 32-bit register bus. A 16-bit down-counter runs from a reload value held in the control register. It advances either on every clock or, when the prescale bit is set, once every 2^PRE_SHIFT clocks. Software keeps the watchdog alive by writing a fixed pair of key values, in order, to a 16-bit service register. If the counter runs out, the block either raises an interrupt that holds until the next valid service, or issues a one-cycle reset request and sets a sticky reset-cause flag. That flag is cleared only by power-on reset or by software writing 1 to it.

The control register accepts one write after power-on reset and then locks. Software reads it back to learn whether its enable request took effect and which reload value is in force. A build variant (`EN_AT_RESET`) starts the watchdog running out of reset. In that variant the single control write may still set the reload value and the mode, but the enable bit stays set.

Three small state machines make up the block:
- Configuration gate, states CFG_OPEN and CFG_LOCKED. It moves from CFG_OPEN to CFG_LOCKED on the first control write.
- Key sequencer, states KEY_IDLE and KEY_ARMED. It moves from KEY_IDLE to KEY_ARMED when the first key is written. From KEY_ARMED it returns to KEY_IDLE on the next service write, which fires a service only if that write is the second key.
- Timer, states T_OFF, T_RUN and T_HOLD:
  - T_OFF to T_RUN on an accepted enable.
  - T_RUN stays in T_RUN through countdown, service and reset-mode expiry.
  - T_RUN to T_HOLD on interrupt-mode expiry.
  - T_HOLD to T_RUN on a valid service.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset the control word reads TC_RESET in bits 31:16, freeze 0, enable EN_AT_RESET, reset-select 1 and prescale 1. With EN_AT_RESET=0 the count, status and reserved word read 0, and both outputs are low.
- R2: The control register sits at byte offset 0x04. Bits 31:16 hold the reload count, bit 3 freeze, bit 2 enable, bit 1 mode (1 = reset request, 0 = interrupt) and bit 0 prescale. All other bits read 0.
- R3: Only the first control write after power-on reset is accepted. Every later write leaves the register unchanged, so an enabled watchdog stays enabled and a disabled one stays disabled.
- R4: An accepted write with enable set loads the counter from the written count on the same edge and restarts the prescaler. The counter reads at offset 0x08, bits 15:0.
- R5: While running, the counter drops by one every 2^PRE_SHIFT clocks with prescale set, and on every clock with prescale clear.
- R6: A service write is a write to offset 0x0E with the key in data bits 15:0. Writing 0x556C and then 0xAA39 as consecutive service writes reloads the counter from the reload count and restarts the prescaler.
- R7: These sequences do not reload the counter: 0xAA39 with no 0x556C before it, any other value after 0x556C, and 0x556C written twice before 0xAA39.
- R8: In interrupt mode, the tick that would take the counter from 1 to 0 (or any tick at 0) raises the interrupt and holds the counter at 0. The interrupt stays high until a valid service clears it and reloads the counter.
- R9: In reset mode, the same expiry issues a reset request exactly one cycle long and reloads the counter from the reload count.
- R10: The status word at offset 0x10, bit 0, is set by a reset request. Writing 1 to it clears it, writing 0 has no effect, and power-on reset clears it.
- R11: While the freeze bit is set and the debug-halt input is high, both the counter and the prescaler hold.
- R12: While disabled, the counter stays at 0, services have no effect and neither output is asserted.
- R13: With EN_AT_RESET=1 the watchdog runs from reset with TC_RESET. The first control write sets the count and mode, but the enable bit stays 1 and the write reloads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| dbg_halt | input | 1 | Debug halt; stops the count when the freeze bit is set |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 5 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wdt_irq | output | 1 | Expiry interrupt, level |
| wdt_rst_req | output | 1 | Expiry reset request, one-cycle pulse |

## Verification
The bench builds two copies of the block, both with PRE_SHIFT=3 so that a prescaled tick comes every 8 clocks. With that setting, many expiries and service windows fit in a short run. One copy uses EN_AT_RESET=0 and TC_RESET=0xFFFF, which brings the write-once enable and disable paths and the reset readback within reach. The other uses EN_AT_RESET=1 and TC_RESET=6, so that its run from reset expires within a few dozen cycles. Random reload counts, modes and wait lengths are checked against closed-form countdown formulas.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_RSVD  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SVC   = 5'h0E;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h10;

    localparam logic [15:0] KEY_ARM  = 16'h556C;
    localparam logic [15:0] KEY_FIRE = 16'hAA39;

    typedef struct packed {
        logic [15:0] tc;
        logic        frz;
        logic        en;
        logic        rsel;
        logic        pre;
    } ctl_t;

    typedef enum logic [0:0] {CFG_OPEN, CFG_LOCKED} cfg_state_e;
    typedef enum logic [0:0] {KEY_IDLE, KEY_ARMED} key_state_e;
    typedef enum logic [1:0] {T_OFF, T_RUN, T_HOLD} tmr_state_e;

    function automatic ctl_t word_to_ctl(input logic [31:0] w);
        ctl_t c;
        c.tc   = w[31:16];
        c.frz  = w[3];
        c.en   = w[2];
        c.rsel = w[1];
        c.pre  = w[0];
        return c;
    endfunction

    function automatic logic [31:0] ctl_to_word(input ctl_t c);
        return {c.tc, 12'h000, c.frz, c.en, c.rsel, c.pre};
    endfunction

endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_keyed_pkg::*;
#(
    parameter bit          EN_AT_RESET = 1'b0,
    parameter logic [15:0] TC_RESET    = 16'hFFFF
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        wr_ctl,
    input  logic        wr_stat,
    input  logic [31:0] wdata,
    input  logic        rst_seen,
    output ctl_t        ctl_o,
    output logic        load_o,
    output logic [15:0] load_tc_o,
    output logic        sticky_o
);

    localparam ctl_t CTL_INIT = '{tc: TC_RESET, frz: 1'b0, en: EN_AT_RESET,
                                  rsel: 1'b1, pre: 1'b1};

    cfg_state_e st_q, st_n;
    ctl_t       ctl_q, ctl_n;
    logic       sticky_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= CFG_OPEN;
            ctl_q <= CTL_INIT;
        end else begin
            st_q  <= st_n;
            ctl_q <= ctl_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        ctl_n  = ctl_q;
        load_o = 1'b0;
        unique case (st_q)
            CFG_OPEN: begin
                if (wr_ctl) begin
                    ctl_n = word_to_ctl(wdata);
                    if (EN_AT_RESET) ctl_n.en = 1'b1;
                    load_o = ctl_n.en;
                    st_n   = CFG_LOCKED;
                end
            end
            CFG_LOCKED: begin
                st_n = CFG_LOCKED;
            end
            default: st_n = CFG_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 sticky_q <= 1'b0;
        else if (rst_seen)          sticky_q <= 1'b1;
        else if (wr_stat && wdata[0]) sticky_q <= 1'b0;
    end

    assign ctl_o     = ctl_q;
    assign load_tc_o = ctl_n.tc;
    assign sticky_o  = sticky_q;

endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_keyed_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        wr_svc,
    input  logic [15:0] key,
    output logic        svc_o
);

    key_state_e st_q, st_n;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= KEY_IDLE;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n  = st_q;
        svc_o = 1'b0;
        unique case (st_q)
            KEY_IDLE: begin
                if (wr_svc && key == KEY_ARM) st_n = KEY_ARMED;
            end
            KEY_ARMED: begin
                if (wr_svc) begin
                    st_n  = KEY_IDLE;
                    svc_o = (key == KEY_FIRE);
                end
            end
            default: st_n = KEY_IDLE;
        endcase
    end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_keyed_pkg::*;
#(
    parameter int          PRE_SHIFT   = 16,
    parameter bit          EN_AT_RESET = 1'b0,
    parameter logic [15:0] TC_RESET    = 16'hFFFF
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic [15:0] tc,
    input  logic        frz,
    input  logic        rsel,
    input  logic        pre,
    input  logic        dbg_halt,
    input  logic        load,
    input  logic [15:0] load_tc,
    input  logic        svc,
    output logic [15:0] cnt_o,
    output logic        irq_o,
    output logic        rst_req_o
);

    localparam int          PRE_W      = (PRE_SHIFT < 1) ? 1 : PRE_SHIFT;
    localparam tmr_state_e  ST_INIT    = EN_AT_RESET ? T_RUN : T_OFF;
    localparam logic [15:0] CNT_INIT   = EN_AT_RESET ? TC_RESET : 16'h0000;

    tmr_state_e       st_q, st_n;
    logic [15:0]      cnt_q, cnt_n;
    logic [PRE_W-1:0] pre_q, pre_n;
    logic             irq_q, irq_n;
    logic             rq_q, rq_n;
    logic             halted, tick;

    assign halted = frz & dbg_halt;
    assign tick   = !halted && (pre ? (&pre_q) : 1'b1);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= ST_INIT;
            cnt_q <= CNT_INIT;
            pre_q <= '0;
            irq_q <= 1'b0;
            rq_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            pre_q <= pre_n;
            irq_q <= irq_n;
            rq_q  <= rq_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        pre_n = pre_q;
        irq_n = irq_q;
        rq_n  = 1'b0;
        unique case (st_q)
            T_OFF: begin
                if (load) begin
                    st_n  = T_RUN;
                    cnt_n = load_tc;
                    pre_n = '0;
                end
            end
            T_RUN: begin
                if (load) begin
                    cnt_n = load_tc;
                    pre_n = '0;
                end else if (svc) begin
                    cnt_n = tc;
                    pre_n = '0;
                end else if (!halted) begin
                    if (pre) pre_n = pre_q + 1'b1;
                    if (tick) begin
                        if (cnt_q <= 16'd1) begin
                            if (rsel) begin
                                rq_n  = 1'b1;
                                cnt_n = tc;
                            end else begin
                                irq_n = 1'b1;
                                cnt_n = 16'd0;
                                st_n  = T_HOLD;
                            end
                        end else begin
                            cnt_n = cnt_q - 16'd1;
                        end
                    end
                end
            end
            T_HOLD: begin
                if (load || svc) begin
                    irq_n = 1'b0;
                    cnt_n = load ? load_tc : tc;
                    pre_n = '0;
                    st_n  = T_RUN;
                end
            end
            default: st_n = T_OFF;
        endcase
    end

    assign cnt_o     = cnt_q;
    assign irq_o     = irq_q;
    assign rst_req_o = rq_q;

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int          PRE_SHIFT   = 16,
    parameter bit          EN_AT_RESET = 1'b0,
    parameter logic [15:0] TC_RESET    = 16'hFFFF
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        dbg_halt,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_irq,
    output logic        wdt_rst_req
);

    logic        wr_ctl, wr_stat, wr_svc;
    logic        load_pulse, svc_pulse, sticky_q;
    logic [15:0] load_tc, cnt_q;
    ctl_t        ctl_q;

    assign wr_ctl  = bus_req && bus_we && (bus_addr == OFS_CTRL);
    assign wr_stat = bus_req && bus_we && (bus_addr == OFS_STAT);
    assign wr_svc  = bus_req && bus_we && (bus_addr == OFS_SVC);

    wdt_cfg #(
        .EN_AT_RESET (EN_AT_RESET),
        .TC_RESET    (TC_RESET)
    ) i_cfg (
        .clk       (clk),
        .por_n     (por_n),
        .wr_ctl    (wr_ctl),
        .wr_stat   (wr_stat),
        .wdata     (bus_wdata),
        .rst_seen  (wdt_rst_req),
        .ctl_o     (ctl_q),
        .load_o    (load_pulse),
        .load_tc_o (load_tc),
        .sticky_o  (sticky_q)
    );

    wdt_keyseq i_keyseq (
        .clk    (clk),
        .por_n  (por_n),
        .wr_svc (wr_svc),
        .key    (bus_wdata[15:0]),
        .svc_o  (svc_pulse)
    );

    wdt_timer #(
        .PRE_SHIFT   (PRE_SHIFT),
        .EN_AT_RESET (EN_AT_RESET),
        .TC_RESET    (TC_RESET)
    ) i_timer (
        .clk       (clk),
        .por_n     (por_n),
        .tc        (ctl_q.tc),
        .frz       (ctl_q.frz),
        .rsel      (ctl_q.rsel),
        .pre       (ctl_q.pre),
        .dbg_halt  (dbg_halt),
        .load      (load_pulse),
        .load_tc   (load_tc),
        .svc       (svc_pulse),
        .cnt_o     (cnt_q),
        .irq_o     (wdt_irq),
        .rst_req_o (wdt_rst_req)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL:  bus_rdata = ctl_to_word(ctl_q);
            OFS_COUNT: bus_rdata = {16'h0000, cnt_q};
            OFS_STAT:  bus_rdata = {31'h0, sticky_q};
            default:   bus_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_keyed_pkg::*;
(
    input logic        clk,
    input logic        por_n,
    input logic        dbg_halt,
    input logic        wr_ctl,
    input logic        svc_pulse,
    input logic        load_pulse,
    input ctl_t        ctl_q,
    input logic [15:0] cnt_q,
    input logic        sticky_q,
    input logic        wdt_irq,
    input logic        wdt_rst_req
);

    logic seen_wr_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      seen_wr_q <= 1'b0;
        else if (wr_ctl) seen_wr_q <= 1'b1;
    end

    assert_ctl_locked_R3: assert property (@(posedge clk) disable iff (!por_n)
        seen_wr_q |=> $stable(ctl_q));

    assert_enable_kept_R3: assert property (@(posedge clk) disable iff (!por_n)
        ctl_q.en |=> ctl_q.en);

    assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_irq && !svc_pulse && !load_pulse) |=> wdt_irq);

    assert_irq_mode_R8: assert property (@(posedge clk) disable iff (!por_n)
        wdt_irq |-> !ctl_q.rsel);

    assert_rst_one_cycle_R9: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |=> !wdt_rst_req);

    assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |=> sticky_q);

    assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
        (ctl_q.frz && dbg_halt && !svc_pulse && !load_pulse) |=> $stable(cnt_q));

    assert_off_quiet_R12: assert property (@(posedge clk) disable iff (!por_n)
        !ctl_q.en |-> (cnt_q == 16'd0 && !wdt_irq && !wdt_rst_req));

endmodule

bind wdt_keyed wdt_keyed_chk i_chk (
    .clk         (clk),
    .por_n       (por_n),
    .dbg_halt    (dbg_halt),
    .wr_ctl      (wr_ctl),
    .svc_pulse   (svc_pulse),
    .load_pulse  (load_pulse),
    .ctl_q       (ctl_q),
    .cnt_q       (cnt_q),
    .sticky_q    (sticky_q),
    .wdt_irq     (wdt_irq),
    .wdt_rst_req (wdt_rst_req)
);

// File: tb/test_wdt_keyed.sv
`timescale 1ns/1ps
module test_wdt_keyed;
    import wdt_keyed_pkg::*;

    localparam int P = 8;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        bus_req = 1'b0, bus_req2 = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata2;
    logic        irq, rst_req, irq2, rst_req2;

    int     n_chk = 0, n_fail = 0;
    longint cyc = 0, t0 = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_keyed #(.PRE_SHIFT(3), .EN_AT_RESET(1'b0), .TC_RESET(16'hFFFF)) i_wdt_keyed (
        .clk(clk), .por_n(por_n), .dbg_halt(dbg_halt), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .wdt_irq(irq), .wdt_rst_req(rst_req));

    wdt_keyed #(.PRE_SHIFT(3), .EN_AT_RESET(1'b1), .TC_RESET(16'd6)) i_wdt_keyed_hw (
        .clk(clk), .por_n(por_n), .dbg_halt(dbg_halt), .bus_req(bus_req2), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
        .wdt_irq(irq2), .wdt_rst_req(rst_req2));

    function automatic logic [31:0] ctl_word(int t, bit f, bit e, bit r, bit pr);
        logic [15:0] tt = t[15:0];
        return {tt, 12'h000, f, e, r, pr};
    endfunction

    function automatic logic [31:0] cnt_irq_mode(int t, int p, int n);
        if (n >= t * p) return 32'd0;
        return 32'(t - n / p);
    endfunction

    function automatic logic [31:0] cnt_rst_mode(int t, int p, int n);
        return 32'(t - (n % (t * p)) / p);
    endfunction

    function automatic int since();
        return int'(cyc - t0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic por();
        @(negedge clk);
        por_n = 1'b0;
        dbg_halt = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        t0 = cyc;
    endtask

    task automatic wr(input bit hw, input logic [4:0] a, input logic [31:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_we = 1'b1;
        if (hw) bus_req2 = 1'b1;
        else    bus_req = 1'b1;
        @(negedge clk);
        bus_req = 1'b0;
        bus_req2 = 1'b0;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v, output logic [31:0] v2);
        bus_addr = a;
        #1;
        v = rdata;
        v2 = rdata2;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        void'($urandom(32'd20240611));

        // Reset values, both builds (R1, R13)
        por();
        rd(OFS_CTRL, v, v2);
        chk("R1 ctrl", v, 32'hFFFF_0003);
        chk("R13 ctrl hw", v2, 32'h0006_0007);
        rd(OFS_COUNT, v, v2);
        chk("R1 count", v, 32'd0);
        chk("R13 count hw", v2, 32'd6);
        rd(OFS_STAT, v, v2);
        chk("R1 status", v, 32'd0);
        rd(OFS_RSVD, v, v2);
        chk("R1 reserved", v, 32'd0);
        chk("R1 outputs", {30'd0, irq, rst_req}, 32'd0);
        idle(8);
        rd(OFS_COUNT, v, v2);
        chk("R13 countdown hw", v2, 32'(6 - since() / P));
        wr(1'b1, OFS_CTRL, ctl_word(3, 0, 0, 1, 0));
        t0 = cyc;
        rd(OFS_CTRL, v, v2);
        chk("R13 enable forced", v2, 32'h0003_0006);
        chk("R1 other copy untouched", v, 32'hFFFF_0003);
        rd(OFS_COUNT, v, v2);
        chk("R13 reload on write", v2, 32'd3);
        idle(3);
        chk("R13 reset request", {31'd0, rst_req2}, 32'd1);

        // Disabled first: stays disabled (R2, R3, R12)
        por();
        wr(1'b0, OFS_CTRL, ctl_word(5, 0, 0, 0, 0));
        rd(OFS_CTRL, v, v2);
        chk("R2 readback", v, 32'h0005_0000);
        wr(1'b0, OFS_CTRL, ctl_word(5, 0, 1, 0, 0));
        rd(OFS_CTRL, v, v2);
        chk("R3 enable refused", v, 32'h0005_0000);
        wr(1'b0, OFS_SVC, 32'h556C);
        wr(1'b0, OFS_SVC, 32'hAA39);
        idle(10);
        rd(OFS_COUNT, v, v2);
        chk("R12 count idle", v, 32'd0);
        chk("R12 outputs", {30'd0, irq, rst_req}, 32'd0);

        // Enabled, prescaled, then key sequences (R2..R7)
        por();
        wr(1'b0, OFS_CTRL, ctl_word(10, 1, 1, 0, 1));
        t0 = cyc;
        rd(OFS_COUNT, v, v2);
        chk("R4 load", v, 32'd10);
        wr(1'b0, OFS_CTRL, ctl_word(3, 0, 0, 1, 0));
        rd(OFS_CTRL, v, v2);
        chk("R2 fields", v, 32'h000A_000D);
        chk("R3 second write ignored", v, 32'h000A_000D);
        idle(19);
        rd(OFS_COUNT, v, v2);
        chk("R5 prescaled rate", v, cnt_irq_mode(10, P, since()));
        wr(1'b0, OFS_SVC, 32'hAA39);
        idle(19);
        rd(OFS_COUNT, v, v2);
        chk("R7 second key alone", v, cnt_irq_mode(10, P, since()));
        wr(1'b0, OFS_SVC, 32'h556C);
        wr(1'b0, OFS_SVC, 32'h1234);
        wr(1'b0, OFS_SVC, 32'hAA39);
        rd(OFS_COUNT, v, v2);
        chk("R7 wrong second word", v, cnt_irq_mode(10, P, since()));
        wr(1'b0, OFS_SVC, 32'h556C);
        wr(1'b0, OFS_SVC, 32'h556C);
        wr(1'b0, OFS_SVC, 32'hAA39);
        rd(OFS_COUNT, v, v2);
        chk("R7 doubled first key", v, cnt_irq_mode(10, P, since()));
        wr(1'b0, OFS_SVC, 32'h556C);
        wr(1'b0, OFS_SVC, 32'hAA39);
        t0 = cyc;
        rd(OFS_COUNT, v, v2);
        chk("R6 valid service", v, 32'd10);
        idle(7);
        rd(OFS_COUNT, v, v2);
        chk("R6 prescaler restarted", v, 32'd10);
        idle(1);
        rd(OFS_COUNT, v, v2);
        chk("R5 first prescaled tick", v, 32'd9);

        // Freeze under debug halt (R11)
        por();
        wr(1'b0, OFS_CTRL, ctl_word(20, 1, 1, 0, 0));
        idle(3);
        rd(OFS_COUNT, v, v2);
        chk("R5 unprescaled rate", v, 32'd17);
        dbg_halt = 1'b1;
        idle(5);
        rd(OFS_COUNT, v, v2);
        chk("R11 held", v, 32'd17);
        dbg_halt = 1'b0;
        idle(2);
        rd(OFS_COUNT, v, v2);
        chk("R11 resumes", v, 32'd15);

        // Interrupt mode hold (R8)
        por();
        wr(1'b0, OFS_CTRL, ctl_word(2, 0, 1, 0, 0));
        idle(2);
        chk("R8 irq raised", {31'd0, irq}, 32'd1);
        idle(10);
        rd(OFS_COUNT, v, v2);
        chk("R8 count held at 0", v, 32'd0);
        chk("R8 irq held", {31'd0, irq}, 32'd1);
        wr(1'b0, OFS_SVC, 32'h556C);
        chk("R8 irq held after first key", {31'd0, irq}, 32'd1);
        wr(1'b0, OFS_SVC, 32'hAA39);
        rd(OFS_COUNT, v, v2);
        chk("R8 irq cleared", {31'd0, irq}, 32'd0);
        chk("R8 reloaded", v, 32'd2);
        idle(2);
        chk("R8 irq again", {31'd0, irq}, 32'd1);

        // Reset mode and sticky flag (R9, R10)
        por();
        wr(1'b0, OFS_CTRL, ctl_word(10, 0, 1, 1, 0));
        idle(9);
        rd(OFS_COUNT, v, v2);
        chk("R9 before expiry", {v[15:0], 15'd0, rst_req}, {16'd1, 16'd0});
        idle(1);
        rd(OFS_COUNT, v, v2);
        chk("R9 request", {31'd0, rst_req}, 32'd1);
        chk("R9 reload", v, 32'd10);
        idle(1);
        rd(OFS_STAT, v, v2);
        chk("R9 one cycle", {31'd0, rst_req}, 32'd0);
        chk("R10 sticky set", v, 32'd1);
        wr(1'b0, OFS_STAT, 32'd0);
        rd(OFS_STAT, v, v2);
        chk("R10 write 0 keeps", v, 32'd1);
        wr(1'b0, OFS_STAT, 32'd1);
        rd(OFS_STAT, v, v2);
        chk("R10 write 1 clears", v, 32'd0);

        // Random configurations and wait lengths (R5, R8, R9, R10)
        for (int it = 0; it < 16; it++) begin
            int t, p, k, n;
            bit pr, rs;
            t  = 1 + int'($urandom_range(11, 0));
            pr = 1'($urandom_range(1, 0));
            rs = 1'($urandom_range(1, 0));
            p  = pr ? P : 1;
            k  = int'($urandom_range(32'(2 * t * p + 2), 0));
            por();
            wr(1'b0, OFS_CTRL, ctl_word(t, 0, 1, rs, pr));
            t0 = cyc;
            idle(k);
            n = since();
            rd(OFS_COUNT, v, v2);
            if (rs) begin
                chk("R5 R9 random count", v, cnt_rst_mode(t, p, n));
                chk("R9 random request", {31'd0, rst_req},
                    {31'd0, (n > 0) && (n % (t * p) == 0)});
                chk("R8 random irq quiet", {31'd0, irq}, 32'd0);
            end else begin
                chk("R5 R8 random count", v, cnt_irq_mode(t, p, n));
                chk("R8 random irq", {31'd0, irq}, {31'd0, n >= t * p});
                chk("R9 random request quiet", {31'd0, rst_req}, 32'd0);
            end
            rd(OFS_STAT, v, v2);
            chk("R10 random sticky", v, {31'd0, rs && (n > t * p)});
        end

        summary();
        $finish;
    end

endmodule